// File: doc/BRIEF.md
# Periodic Input Level Monitor

This block watches a stream of sample magnitudes and, once per programmable measurement window, reports one statistic of that window. Three statistics are available: the largest magnitude, an integrated power figure, or the count of samples whose magnitude exceeds a threshold. One shared down-counter sets the window length, and one working register collects the statistic. At each window end the result is moved to a holding register. An interrupt pulse and a sticky status bit can flag that moment.

Windows follow one another with no gap. The power statistic keeps the sample that arrives on the window-end cycle as the first value of the next window. The peak statistic does the same. The threshold count restarts from zero. Power results are packed as a floating-point word with a 4-bit exponent above a 20-bit mantissa. The internal power accumulator and the threshold counter both saturate at all ones rather than wrapping.

Top module: `lvl_mon`

## Requirements
- R1: After reset, `hold_q` is 0, `irq` is 0 and `sts` is 0.
- R2: `mode` 00 selects peak, 01 selects power integration, and 10 or 11 selects threshold counting. Moving between 10 and 11 while running does not restart the window or disturb the count.
- R3: On the first enabled cycle, and on any cycle where the decoded statistic changes, the counter loads `period` and the working value clears; a `period` of 0 acts as 1. Each window ends `period` cycles after the previous load or window end. At that edge, `hold_q` takes the window's result.
- R4: A new `period` value takes effect only at the next reload. A window in progress keeps its length.
- R5: In peak mode, the working value changes only when a valid sample's `smp_mag` is strictly greater than it. `hold_q` holds the zero-extended peak. A valid sample on the window-end cycle becomes the first value of the next window.
- R6: In power mode, each valid sample adds `smp_pwr >> 9` to a 24-bit accumulator. On the window-end cycle, the accumulator is loaded with that sample's contribution, or 0 if no sample is valid.
- R7: In power mode, `hold_q[23:20]` is E = min(number of leading zeros of the accumulator, 15). `hold_q[19:0]` is bits 23..4 of the accumulator shifted left by E.
- R8: In threshold mode, each valid sample with `smp_mag` strictly greater than `thresh` adds one to the count. The count is 0 after every window end, and the sample on the window-end cycle is not counted.
- R9: Samples with `smp_vld` low have no effect on any statistic.
- R10: `irq` is high for the single cycle after a window end, and only if `irq_en` was high on the window-end cycle. That same event sets `sts`. `sts_clr` clears `sts`, but a set in the same cycle wins.
- R11: While `en` is low, no window ends, `irq` stays low and `hold_q` keeps its value. Raising `en` again starts a fresh window as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Runs the monitor |
| mode | input | 2 | Statistic select |
| period | input | 24 | Window length in cycles |
| thresh | input | 10 | Upper threshold for counting |
| irq_en | input | 1 | Allows the interrupt and the status set |
| smp_vld | input | 1 | Sample present this cycle |
| smp_mag | input | 10 | Sample absolute magnitude |
| smp_pwr | input | 15 | Sample power |
| sts_clr | input | 1 | Clears the sticky status |
| hold_q | output | 24 | Last window result |
| irq | output | 1 | Window-end interrupt pulse |
| sts | output | 1 | Sticky window-end status |

## Verification
The bench runs each statistic under random magnitudes, powers and thresholds, with short random periods. This separates the strict comparisons from non-strict ones and shows whether the window-end sample is carried into the next window or dropped. A long full-scale power window, together with one-cycle windows of tiny power, exercises both the normalised and the saturated exponent. Streams with sparse valid samples, periods that change mid-window, mode toggles inside the threshold encoding, and random enable, interrupt-enable and clear patterns each show whether the window timing, sample gating and status logic follow the rules or leak state.

// File: rtl/lvl_mon_pkg.sv
package lvl_mon_pkg;

  typedef enum logic [1:0] {
    K_PEAK = 2'd0,
    K_MEAN = 2'd1,
    K_THR  = 2'd2
  } stat_kind_t;

  // The high bit alone selects counting; the low bit only matters when it is clear.
  function automatic stat_kind_t decode_mode(input logic [1:0] m);
    if (m[1]) return K_THR;
    if (m[0]) return K_MEAN;
    return K_PEAK;
  endfunction

endpackage

// File: rtl/lvl_mon_timer.sv
module lvl_mon_timer
  import lvl_mon_pkg::*;
#(
  parameter int PERIOD_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  stat_kind_t          kind,
  input  logic [PERIOD_W-1:0] period,
  output logic                run_q,
  output logic [PERIOD_W-1:0] cnt_q,
  output logic                restart,
  output logic                win_end
);

  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  stat_kind_t          kind_q;
  logic [PERIOD_W-1:0] ld_val;

  function automatic logic [PERIOD_W-1:0] reload_val(input logic [PERIOD_W-1:0] p);
    return (p == '0) ? ONE : p;
  endfunction

  assign ld_val  = reload_val(period);
  assign restart = en && (!run_q || (kind != kind_q));
  assign win_end = en && run_q && (kind == kind_q) && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      kind_q <= K_PEAK;
    end else begin
      kind_q <= kind;
      if (!en) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (restart || win_end) begin
        run_q <= 1'b1;
        cnt_q <= ld_val;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

endmodule

// File: rtl/lvl_mon_accum.sv
module lvl_mon_accum
  import lvl_mon_pkg::*;
#(
  parameter int MAG_W     = 10,
  parameter int THR_W     = 10,
  parameter int PWR_W     = 15,
  parameter int PWR_SHIFT = 9,
  parameter int ACC_W     = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             win_end,
  input  stat_kind_t       kind,
  input  logic             smp_vld,
  input  logic [MAG_W-1:0] smp_mag,
  input  logic [PWR_W-1:0] smp_pwr,
  input  logic [THR_W-1:0] thresh,
  output logic [ACC_W-1:0] work_q
);

  localparam int CMP_W = (MAG_W > THR_W) ? MAG_W : THR_W;

  logic [ACC_W-1:0] work_d;
  logic [ACC_W-1:0] mag_ext;
  logic [ACC_W-1:0] pwr_part;
  logic             above_thr;

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ACC_W] ? {ACC_W{1'b1}} : s[ACC_W-1:0];
  endfunction

  function automatic logic [ACC_W-1:0] power_part(input logic [PWR_W-1:0] p);
    return ACC_W'(p >> PWR_SHIFT);
  endfunction

  assign mag_ext   = ACC_W'(smp_mag);
  assign pwr_part  = power_part(smp_pwr);
  assign above_thr = CMP_W'(smp_mag) > CMP_W'(thresh);

  always_comb begin
    work_d = work_q;
    if (!en || restart) begin
      work_d = '0;
    end else if (win_end) begin
      unique case (kind)
        K_PEAK:  work_d = smp_vld ? mag_ext : '0;
        K_MEAN:  work_d = smp_vld ? pwr_part : '0;
        default: work_d = '0;
      endcase
    end else if (smp_vld) begin
      unique case (kind)
        K_PEAK:  if (mag_ext > work_q) work_d = mag_ext;
        K_MEAN:  work_d = sat_add(work_q, pwr_part);
        default: if (above_thr) work_d = sat_add(work_q, ACC_W'(1));
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) work_q <= '0;
    else        work_q <= work_d;
  end

endmodule

// File: rtl/lvl_mon_report.sv
module lvl_mon_report
  import lvl_mon_pkg::*;
#(
  parameter int EXP_W  = 4,
  parameter int MANT_W = 20,
  parameter int ACC_W  = EXP_W + MANT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  stat_kind_t       kind,
  input  logic [ACC_W-1:0] work_q,
  input  logic             irq_en,
  input  logic             sts_clr,
  output logic [ACC_W-1:0] hold_q,
  output logic             irq,
  output logic             sts
);

  localparam int EXP_MAX = (1 << EXP_W) - 1;

  logic fire;

  // Normalise: shift left by the leading-zero count, capped at EXP_MAX.
  function automatic logic [ACC_W-1:0] pack_float(input logic [ACC_W-1:0] v);
    int               lz;
    int               e;
    logic [ACC_W-1:0] sh;
    lz = ACC_W;
    for (int i = 0; i < ACC_W; i++) begin
      if (v[i]) lz = ACC_W - 1 - i;
    end
    e  = (lz > EXP_MAX) ? EXP_MAX : lz;
    sh = v << e;
    return {EXP_W'(e), sh[ACC_W-1 -: MANT_W]};
  endfunction

  assign fire = win_end && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      irq    <= 1'b0;
      sts    <= 1'b0;
    end else begin
      if (win_end) hold_q <= (kind == K_MEAN) ? pack_float(work_q) : work_q;
      irq <= fire;
      if (fire)         sts <= 1'b1;
      else if (sts_clr) sts <= 1'b0;
    end
  end

endmodule

// File: rtl/lvl_mon.sv
module lvl_mon
  import lvl_mon_pkg::*;
#(
  parameter int PERIOD_W  = 24,
  parameter int MAG_W     = 10,
  parameter int THR_W     = 10,
  parameter int PWR_W     = 15,
  parameter int PWR_SHIFT = 9,
  parameter int EXP_W     = 4,
  parameter int MANT_W    = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [1:0]              mode,
  input  logic [PERIOD_W-1:0]     period,
  input  logic [THR_W-1:0]        thresh,
  input  logic                    irq_en,
  input  logic                    smp_vld,
  input  logic [MAG_W-1:0]        smp_mag,
  input  logic [PWR_W-1:0]        smp_pwr,
  input  logic                    sts_clr,
  output logic [EXP_W+MANT_W-1:0] hold_q,
  output logic                    irq,
  output logic                    sts
);

  localparam int ACC_W = EXP_W + MANT_W;

  stat_kind_t          kind;
  logic                tmr_run;
  logic [PERIOD_W-1:0] cnt_q;
  logic                restart;
  logic                win_end;
  logic [ACC_W-1:0]    work_q;

  assign kind = decode_mode(mode);

  lvl_mon_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .kind    (kind),
    .period  (period),
    .run_q   (tmr_run),
    .cnt_q   (cnt_q),
    .restart (restart),
    .win_end (win_end)
  );

  lvl_mon_accum #(
    .MAG_W     (MAG_W),
    .THR_W     (THR_W),
    .PWR_W     (PWR_W),
    .PWR_SHIFT (PWR_SHIFT),
    .ACC_W     (ACC_W)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .restart (restart),
    .win_end (win_end),
    .kind    (kind),
    .smp_vld (smp_vld),
    .smp_mag (smp_mag),
    .smp_pwr (smp_pwr),
    .thresh  (thresh),
    .work_q  (work_q)
  );

  lvl_mon_report #(
    .EXP_W  (EXP_W),
    .MANT_W (MANT_W),
    .ACC_W  (ACC_W)
  ) u_report (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_end (win_end),
    .kind    (kind),
    .work_q  (work_q),
    .irq_en  (irq_en),
    .sts_clr (sts_clr),
    .hold_q  (hold_q),
    .irq     (irq),
    .sts     (sts)
  );

endmodule

// File: rtl/lvl_mon_chk.sv
module lvl_mon_chk
  import lvl_mon_pkg::*;
#(
  parameter int PERIOD_W = 24,
  parameter int ACC_W    = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                irq_en,
  input logic                irq,
  input logic                sts,
  input logic [PERIOD_W-1:0] period,
  input logic [PERIOD_W-1:0] cnt_q,
  input logic                tmr_run,
  input logic                restart,
  input logic                win_end,
  input stat_kind_t          kind,
  input logic [ACC_W-1:0]    work_q,
  input logic [ACC_W-1:0]    hold_q
);

  logic steady;
  assign steady = en && tmr_run && !restart && !win_end;

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> cnt_q == (($past(period) == '0) ? PERIOD_W'(1) : $past(period)));

  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    steady |=> cnt_q == $past(cnt_q) - PERIOD_W'(1));

  a_r5_peak_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && kind == K_PEAK) |=> work_q >= $past(work_q));

  a_r6_mean_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && kind == K_MEAN) |=> work_q >= $past(work_q));

  a_r8_step_of_one: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && kind == K_THR) |=>
      (work_q == $past(work_q) || work_q == $past(work_q) + ACC_W'(1)));

  a_r8_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && kind == K_THR) |=> work_q == '0);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));

  a_r10_irq_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts);

  a_r11_hold_kept_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> $stable(hold_q));

endmodule

bind lvl_mon lvl_mon_chk #(.PERIOD_W(PERIOD_W), .ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .irq_en  (irq_en),
  .irq     (irq),
  .sts     (sts),
  .period  (period),
  .cnt_q   (cnt_q),
  .tmr_run (tmr_run),
  .restart (restart),
  .win_end (win_end),
  .kind    (kind),
  .work_q  (work_q),
  .hold_q  (hold_q)
);

// File: tb/lvl_mon_tb.sv
`timescale 1ns/1ps
module lvl_mon_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [23:0] period = 24'd1;
  logic [9:0]  thresh = 10'd0;
  logic        irq_en = 1'b0;
  logic        smp_vld = 1'b0;
  logic [9:0]  smp_mag = 10'd0;
  logic [14:0] smp_pwr = 15'd0;
  logic        sts_clr = 1'b0;
  logic [23:0] hold_q;
  logic        irq;
  logic        sts;

  always #4 clk = ~clk;

  lvl_mon u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .period(period),
    .thresh(thresh), .irq_en(irq_en), .smp_vld(smp_vld), .smp_mag(smp_mag),
    .smp_pwr(smp_pwr), .sts_clr(sts_clr), .hold_q(hold_q), .irq(irq), .sts(sts)
  );

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // Reference state, updated once per rising edge.
  bit          m_run;
  int          m_kind;
  int unsigned m_cnt;
  int unsigned m_work;
  logic [23:0] m_hold;
  bit          m_irq;
  bit          m_sts;

  localparam int unsigned FULL = 24'hFFFFFF;

  function automatic int kind_of(input logic [1:0] m);
    if (m == 2'b00) return 0;
    if (m == 2'b01) return 1;
    return 2;
  endfunction

  function automatic logic [23:0] ref_pack(input int unsigned w);
    logic [23:0] v;
    int          e;
    v = w[23:0];
    e = 0;
    while (e < 15 && v[23] == 1'b0) begin
      v = v << 1;
      e++;
    end
    return {e[3:0], v[23:4]};
  endfunction

  task automatic ref_step();
    int          k;
    int unsigned ld;
    int unsigned part;
    bit          fin;
    k    = kind_of(mode);
    ld   = (period == 0) ? 1 : period;
    part = smp_pwr >> 9;
    fin  = 1'b0;
    if (!en) begin
      m_run = 0; m_cnt = 0; m_work = 0;
    end else if (!m_run || k != m_kind) begin
      m_run = 1; m_cnt = ld; m_work = 0;
    end else if (m_cnt == 1) begin
      fin    = 1'b1;
      m_hold = (k == 1) ? ref_pack(m_work) : m_work[23:0];
      m_cnt  = ld;
      if (k == 0)      m_work = smp_vld ? smp_mag : 0;
      else if (k == 1) m_work = smp_vld ? part : 0;
      else             m_work = 0;
    end else begin
      m_cnt--;
      if (smp_vld) begin
        if (k == 0) begin
          if (smp_mag > m_work) m_work = smp_mag;
        end else if (k == 1) begin
          m_work = (m_work + part > FULL) ? FULL : m_work + part;
        end else if (smp_mag > thresh) begin
          m_work = (m_work + 1 > FULL) ? FULL : m_work + 1;
        end
      end
    end
    m_kind = k;
    m_irq  = fin && irq_en;
    if (fin && irq_en) m_sts = 1'b1;
    else if (sts_clr)  m_sts = 1'b0;
  endtask

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all();
    check("hold_q", {8'd0, hold_q}, {8'd0, m_hold});
    check("irq", {31'd0, irq}, {31'd0, m_irq});
    check("sts", {31'd0, sts}, {31'd0, m_sts});
  endtask

  // Inputs are set at the falling edge; the reference steps at the rising edge.
  task automatic tick();
    @(posedge clk);
    ref_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic rand_sample(input int vld_pct);
    smp_vld = ($urandom_range(99) < vld_pct);
    smp_mag = 10'($urandom);
    smp_pwr = 15'($urandom);
  endtask

  task automatic run_random(input int cycles, input int pmin, input int pmax,
                            input int vld_pct, input int clr_pct);
    for (int i = 0; i < cycles; i++) begin
      rand_sample(vld_pct);
      sts_clr = ($urandom_range(99) < clr_pct);
      tick();
      if (i % 37 == 36) period = 24'($urandom_range(pmax, pmin));
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    m_run = 0; m_kind = 0; m_cnt = 0; m_work = 0;
    m_hold = '0; m_irq = 0; m_sts = 0;

    // R1: reset values
    tag = "R1";
    repeat (3) @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    irq_en = 1'b1;
    en     = 1'b1;

    tag = "R5"; mode = 2'b00; period = 24'd7;
    run_random(500, 1, 16, 100, 5);

    tag = "R6"; mode = 2'b01; period = 24'd9;
    run_random(500, 3, 40, 100, 5);

    // R7: wide window at full power, then one-cycle windows with tiny power
    tag = "R7"; period = 24'd300;
    for (int i = 0; i < 1500; i++) begin
      smp_vld = 1'b1; smp_mag = 10'h3FF; smp_pwr = 15'h7FFF;
      tick();
    end
    period = 24'd1;
    for (int i = 0; i < 40; i++) begin
      smp_vld = 1'b1; smp_mag = 10'd0; smp_pwr = 15'($urandom_range(2047));
      tick();
    end
    period = 24'd2000;
    for (int i = 0; i < 4100; i++) begin
      rand_sample(100);
      tick();
    end

    tag = "R8"; mode = 2'b10; period = 24'd11;
    for (int j = 0; j < 6; j++) begin
      thresh = 10'($urandom);
      run_random(80, 2, 25, 100, 5);
    end
    thresh = 10'd512;
    for (int i = 0; i < 60; i++) begin
      smp_vld = 1'b1; smp_mag = (i % 2 == 0) ? 10'd512 : 10'd513;
      tick();
    end

    // R2: low mode bit flips inside counting must not restart
    tag = "R2"; thresh = 10'd300; period = 24'd13;
    for (int i = 0; i < 400; i++) begin
      rand_sample(100);
      if (i % 5 == 0) mode[0] = ~mode[0];
      if (i == 350) mode = 2'b00;
      tick();
    end
    mode = 2'b01;
    run_random(60, 4, 9, 100, 0);

    // R3: degenerate and short periods, plus restart on statistic change
    tag = "R3";
    for (int p = 0; p < 4; p++) begin
      period = 24'(p);
      for (int i = 0; i < 40; i++) begin
        rand_sample(100);
        tick();
      end
      mode = (mode == 2'b01) ? 2'b00 : 2'b01;
    end

    // R4: period moves every cycle; only reloads may pick it up
    tag = "R4"; mode = 2'b00;
    for (int i = 0; i < 500; i++) begin
      rand_sample(100);
      period = 24'($urandom_range(20, 1));
      tick();
    end

    tag = "R9";
    for (int j = 0; j < 3; j++) begin
      mode = 2'(j); thresh = 10'd400;
      run_random(300, 2, 30, 25, 5);
    end

    tag = "R10";
    for (int i = 0; i < 600; i++) begin
      rand_sample(100);
      irq_en  = ($urandom_range(99) < 60);
      sts_clr = ($urandom_range(99) < 30);
      if (i % 100 == 0) mode = 2'($urandom);
      period = 24'($urandom_range(6, 1));
      tick();
    end
    irq_en = 1'b1;

    tag = "R11";
    for (int i = 0; i < 600; i++) begin
      rand_sample(100);
      sts_clr = ($urandom_range(99) < 5);
      if ($urandom_range(99) < 8) en = ~en;
      if (i % 150 == 0) mode = 2'($urandom);
      period = 24'($urandom_range(10, 1));
      tick();
    end
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      rand_sample(100);
      tick();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule